// File: doc/BRIEF.md
# Pulse-Coded Serial ADC Conversion Controller

This block runs a small serial ADC from the host side. One output line starts a conversion, and the same line also picks the input: a single long high phase selects the primary channel, which reads as unipolar. A short high pulse, a short low gap and then a long high phase selects the secondary channel, which reads as bipolar. The controller holds the line high for the acquisition time and then drops it, which makes the device sample. It then waits out the conversion delay and clocks in a full 12-bit frame with a counter-derived serial clock. It returns the 10-bit result, widened to the output width, together with the mode that was used.

Each request is a one-bit mode on a valid/ready handshake. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole conversion, so the requester holds its request until the controller can take it. A request shown while the controller is busy has no effect. The result comes out as a one-cycle `res_valid` strobe with no back-pressure, so the consumer must capture it in that cycle. Every timing value is a parameter in nanoseconds and is rounded up to whole system-clock cycles.

Top module: `adc_pulse_ctl`

## Requirements
- R1: While and after the synchronous active-high reset, `conv_start` and `sclk` are low, `busy` is low, `req_ready` is high and `res_valid` is low.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. From the cycle after acceptance until the result, `busy` is high and `req_ready` is low. Requests shown during that time have no effect on the start line pattern, on the mode reported or on the number of results.
- R3: With `req_mode` = 0 (primary channel, unipolar), `conv_start` rises once and stays high for exactly the acquisition length in cycles before it falls.
- R4: With `req_mode` = 1 (secondary channel, bipolar), `conv_start` is high for the pulse length, low for the pulse length, and then high for the acquisition length, giving two rising edges per conversion.
- R5: After the final falling edge of `conv_start`, no rising edge of `sclk` occurs for at least the conversion-wait length in cycles.
- R6: Each conversion gives exactly 12 rising edges of `sclk` before the result strobe. `sclk` is low outside the readout and whenever `conv_start` is high. `sdata` is sampled on each rising `sclk` edge, first bit first.
- R7: The result is the first 10 sampled bits, with the first bit as bit 9. The last two sampled bits are discarded.
- R8: In mode 0, `res_data` is the 10-bit result zero-extended. In mode 1 it is sign-extended from bit 9. `res_mode` equals the accepted `req_mode`.
- R9: `res_valid` is high for exactly one cycle per accepted request.
- R10: Each duration equals its nanosecond parameter times the clock frequency, rounded up to whole cycles. At 125 MHz the 30 ns pulse is 4 cycles, the 1400 ns acquisition is 175 cycles and the 3700 ns wait is 463 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request present |
| req_mode | input | 1 | 0 = primary/unipolar, 1 = secondary/bipolar |
| req_ready | output | 1 | Controller idle and able to take a request |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | OUT_W (16) | Zero- or sign-extended 10-bit result |
| res_mode | output | 1 | Mode used for this result |
| conv_start | output | 1 | Conversion-start and select line to the ADC |
| sclk | output | 1 | Serial clock to the ADC, idle low |
| sdata | input | 1 | Serial data from the ADC |

## Verification
The bench models the ADC. It shifts a known frame out on `sclk` falling edges and measures every high and low phase of `conv_start`. If the double-pulse encoding were wrong, a bipolar request would show the wrong number of rising edges or the wrong phase lengths. If the rounding were off, the 30 ns phases would last 3 cycles instead of 4. A readout that stopped early would leave fewer than 12 `sclk` rises, which would force the device into the secondary channel on the next start. Sign-extension errors show up on frames whose bit 9 is set, and a request driven during a busy conversion must change neither the start pattern nor the number of results.

// File: rtl/adc_pulse_ctl_pkg.sv
package adc_pulse_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRE_HI = 3'd1,
    ST_PRE_LO = 3'd2,
    ST_ACQ    = 3'd3,
    ST_CONV   = 3'd4,
    ST_READ   = 3'd5
  } ctl_state_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned hz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = ns * hz;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign last_o = (cnt_q == '0);

  // R10: without a reload the count only steps down by one or rests at zero
  a_r10_timer_steps: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (cnt_q == '0 || cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int unsigned FRAME_BITS = 12,
  parameter int unsigned RES_BITS   = 10,
  parameter int unsigned HALF_CYC   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go_i,
  input  logic                sdata_i,
  output logic                sclk_o,
  output logic                fin_o,
  output logic [RES_BITS-1:0] data_o
);
  localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned BW = $clog2(FRAME_BITS + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

  logic                  active_q;
  logic                  sclk_q;
  logic                  fin_q;
  logic [HW-1:0]         hcnt_q;
  logic [BW-1:0]         bitcnt_q;
  logic [FRAME_BITS-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      fin_q    <= 1'b0;
      hcnt_q   <= '0;
      bitcnt_q <= '0;
      shreg_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b0;
        hcnt_q   <= HALF_LAST;
        bitcnt_q <= '0;
      end else if (active_q) begin
        if (hcnt_q != '0) begin
          hcnt_q <= hcnt_q - HW'(1);
        end else begin
          hcnt_q <= HALF_LAST;
          if (!sclk_q) begin
            sclk_q  <= 1'b1;
            shreg_q <= {shreg_q[FRAME_BITS-2:0], sdata_i};
          end else begin
            sclk_q <= 1'b0;
            if (bitcnt_q == BIT_LAST) begin
              active_q <= 1'b0;
              fin_q    <= 1'b1;
            end else begin
              bitcnt_q <= bitcnt_q + BW'(1);
            end
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign fin_o  = fin_q;
  assign data_o = shreg_q[FRAME_BITS-1 -: RES_BITS];

  // R6: serial clock idles low whenever no frame is being read
  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !sclk_q);

  // R6: the frame ends only after the last bit position
  a_r6_full_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(fin_q) |-> $past(bitcnt_q) == BIT_LAST);

endmodule

// File: rtl/adc_pulse_ctl.sv
module adc_pulse_ctl
  import adc_pulse_ctl_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 125_000_000,
  parameter longint unsigned PULSE_NS     = 30,
  parameter longint unsigned ACQ_NS       = 1400,
  parameter longint unsigned CONV_NS      = 3700,
  parameter longint unsigned SCLK_HALF_NS = 40,
  parameter int unsigned     FRAME_BITS   = 12,
  parameter int unsigned     RES_BITS     = 10,
  parameter int unsigned     OUT_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_mode,
  output logic             req_ready,
  output logic             busy,
  output logic             res_valid,
  output logic [OUT_W-1:0] res_data,
  output logic             res_mode,
  output logic             conv_start,
  output logic             sclk,
  input  logic             sdata
);
  localparam int unsigned PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_HZ);
  localparam int unsigned ACQ_CYC   = ns_to_cycles(ACQ_NS, CLK_HZ);
  localparam int unsigned CONV_CYC  = ns_to_cycles(CONV_NS, CLK_HZ);
  localparam int unsigned HALF_CYC  = ns_to_cycles(SCLK_HALF_NS, CLK_HZ);
  localparam int unsigned MAX_CYC   = max3(PULSE_CYC, ACQ_CYC, CONV_CYC);
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);
  localparam int unsigned EXT_W     = OUT_W - RES_BITS;

  ctl_state_e          state_q, state_d;
  logic                mode_q;
  logic                load;
  logic [CW-1:0]       len;
  logic                t_last;
  logic                rd_go;
  logic                rd_fin;
  logic [RES_BITS-1:0] rd_data;
  logic                start_q;
  logic                rv_q;
  logic [OUT_W-1:0]    rdata_q;
  logic                accept;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = req_mode ? ST_PRE_HI : ST_ACQ;
      ST_PRE_HI: if (t_last)    state_d = ST_PRE_LO;
      ST_PRE_LO: if (t_last)    state_d = ST_ACQ;
      ST_ACQ:    if (t_last)    state_d = ST_CONV;
      ST_CONV:   if (t_last)    state_d = ST_READ;
      ST_READ:   if (rd_fin)    state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_PRE_HI, ST_PRE_LO: len = CW'(PULSE_CYC);
      ST_ACQ:               len = CW'(ACQ_CYC);
      ST_CONV:              len = CW'(CONV_CYC);
      default:              len = CW'(1);
    endcase
  end

  assign load  = (state_d != state_q);
  assign rd_go = (state_d == ST_READ) && (state_q != ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      start_q <= 1'b0;
      rv_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      start_q <= (state_d == ST_PRE_HI) || (state_d == ST_ACQ);
      rv_q    <= 1'b0;
      if (accept) mode_q <= req_mode;
      if (rd_fin && state_q == ST_READ) begin
        rv_q <= 1'b1;
        if (mode_q) rdata_q <= {{EXT_W{rd_data[RES_BITS-1]}}, rd_data};
        else        rdata_q <= {{EXT_W{1'b0}}, rd_data};
      end
    end
  end

  adc_phase_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .len_i (len),
    .last_o(t_last)
  );

  adc_serial_reader #(
    .FRAME_BITS(FRAME_BITS),
    .RES_BITS  (RES_BITS),
    .HALF_CYC  (HALF_CYC)
  ) u_reader (
    .clk    (clk),
    .rst    (rst),
    .go_i   (rd_go),
    .sdata_i(sdata),
    .sclk_o (sclk),
    .fin_o  (rd_fin),
    .data_o (rd_data)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign conv_start = start_q;
  assign res_valid  = rv_q;
  assign res_data   = rdata_q;
  assign res_mode   = mode_q;

  // R6: never clock the serial port while the start line is high
  a_r6_no_sclk_in_track: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !sclk);

  // R9: result strobe lasts one cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R2: an accepted request makes the block busy in the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  // R2: the mode may only change through an accepted request
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(res_mode));

  // R8: a bipolar negative result is sign-extended
  a_r8_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_mode && res_data[RES_BITS-1]) |-> res_data[OUT_W-1]);

  // R8: a unipolar result has no upper bits set
  a_r8_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_mode) |-> (res_data[OUT_W-1:RES_BITS] == '0));

  // R1: no start pulse while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !conv_start && !sclk);

endmodule

// File: tb/sim_adc_pulse_ctl.sv
module sim_adc_pulse_ctl;
  localparam int PULSE_CYC = (30 * 125 + 999) / 1000;
  localparam int ACQ_CYC   = (1400 * 125 + 999) / 1000;
  localparam int CONV_CYC  = (3700 * 125 + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_mode = 1'b0;
  logic        req_ready, busy, res_valid, res_mode, conv_start, sclk;
  logic [15:0] res_data;
  logic        sdata = 1'b0;

  always #4 clk = ~clk;

  adc_pulse_ctl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_ready(req_ready), .busy(busy), .res_valid(res_valid),
    .res_data(res_data), .res_mode(res_mode), .conv_start(conv_start),
    .sclk(sclk), .sdata(sdata)
  );

  typedef struct { logic mode; logic [11:0] frame; } item_t;
  item_t sb_q[$];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_data(input logic m, input logic [11:0] f);
    logic [9:0] raw;
    raw = f[11:2];
    return m ? {{6{raw[9]}}, raw} : {6'b0, raw};
  endfunction

  // ADC model and monitor, all at the falling clock edge
  int cyc = 0, rises = 0, hi_run = 0, lo_run = 0, gap = 0, first_hi = 0, last_hi = 0;
  int fall_t = 0, nsclk = 0, bitidx = 0, results = 0;
  logic p_start = 0, p_sclk = 0, p_valid = 0;
  logic [11:0] cur_frame = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (conv_start) begin
        if (!p_start) begin
          rises++;
          if (rises > 1) gap = lo_run;
          hi_run = 0;
        end
        hi_run++;
      end else begin
        if (p_start) begin
          if (rises == 1) first_hi = hi_run;
          last_hi = hi_run;
          fall_t = cyc;
          cur_frame = (sb_q.size() > 0) ? sb_q[0].frame : 12'h000;
          bitidx = 11;
          sdata <= cur_frame[11];
          lo_run = 0;
        end
        lo_run++;
      end
      if (sclk && !p_sclk) begin
        nsclk++;
        if (nsclk == 1)
          chk(cyc - fall_t >= CONV_CYC, "R5 wait before first sclk", cyc - fall_t, CONV_CYC);
        chk(!conv_start, "R6 sclk while start high", int'(conv_start), 0);
      end
      if (!sclk && p_sclk) begin
        bitidx--;
        sdata <= (bitidx >= 0) ? cur_frame[bitidx] : 1'b0;
      end
      if (res_valid) begin
        chk(!p_valid, "R9 strobe one cycle", int'(p_valid), 0);
        if (sb_q.size() == 0) begin
          chk(0, "R2 unexpected result", 1, 0);
        end else begin
          item_t e;
          e = sb_q.pop_front();
          results++;
          chk(res_data == expect_data(e.mode, e.frame), "R7 R8 result data",
              int'(res_data), int'(expect_data(e.mode, e.frame)));
          chk(res_mode == e.mode, "R8 result mode", int'(res_mode), int'(e.mode));
          chk(nsclk == 12, "R6 sclk rises per frame", nsclk, 12);
          chk(last_hi == ACQ_CYC, "R3 R4 R10 acquisition length", last_hi, ACQ_CYC);
          if (e.mode) begin
            chk(rises == 2, "R4 start rises", rises, 2);
            chk(first_hi == PULSE_CYC, "R4 R10 first pulse", first_hi, PULSE_CYC);
            chk(gap == PULSE_CYC, "R4 R10 low gap", gap, PULSE_CYC);
          end else begin
            chk(rises == 1, "R3 start rises", rises, 1);
          end
        end
        rises = 0; nsclk = 0; gap = 0; first_hi = 0; last_hi = 0;
      end
      if (!busy && !res_valid)
        if (sclk || conv_start) chk(0, "R1 R6 idle lines", int'(sclk) + int'(conv_start), 0);
    end
    p_start = conv_start;
    p_sclk  = sclk;
    p_valid = res_valid;
  end

  task automatic issue(input logic m, input logic [11:0] f);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.mode = m; it.frame = f;
    sb_q.push_back(it);
    req_valid = 1'b1;
    req_mode  = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R2 busy after accept", int'(busy), 1);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!conv_start && !sclk, "R1 lines low in reset", int'(conv_start) + int'(sclk), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !busy, "R1 idle after reset", int'(req_ready), 1);
    chk(!res_valid, "R1 no result after reset", int'(res_valid), 0);

    issue(1'b0, 12'hABC); drain();
    issue(1'b1, 12'h803); drain();
    issue(1'b1, 12'h5FF); drain();
    issue(1'b0, 12'hFFF); drain();
    issue(1'b0, 12'h000); drain();
    issue(1'b1, 12'hFFC); drain();

    // R2: requests during a busy conversion are ignored
    issue(1'b0, 12'h6A5);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_mode = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (req_ready) break;
    end
    req_valid = 1'b0;
    drain();
    repeat (50) @(negedge clk);
    chk(results == 7, "R2 result count", results, 7);
    chk(!conv_start, "R2 no extra start", int'(conv_start), 0);

    // back-to-back requests
    issue(1'b1, 12'h400);
    issue(1'b0, 12'h3FE);
    drain();
    chk(results == 9, "R9 one result per request", results, 9);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule